// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This unit records the moment an external event happens. Up to 64 asynchronous event lines come in, and a 6-bit selector picks one of them. That line passes through a two-flop synchronizer. A third flop then holds the previous sample, so that an edge can be detected. When capture is enabled and the chosen line shows an edge of the configured direction, the unit stores the live time from the time-of-day counter in a 64-bit register. The seconds sit in the upper 32 bits and the nanoseconds in the lower 32 bits, and both are taken from the same clock cycle.

A valid flag marks a fresh capture. A later capture overwrites the register and keeps the flag set. A one-cycle read strobe tells the unit that the value was consumed, and the flag clears. If a capture and a read strobe fall in the same cycle, the capture wins. Edge detection stays disarmed until the synchronizer pipeline has been refilled after reset. A line that is already high at reset therefore does not look like an edge.

Top module: `evt_stamp_capture`

## Requirements
- R1: While reset is asserted, and right after it, `cap_valid` is 0 and `cap_value` is 0.
- R2: With `edge_rise`=1, a 0-to-1 transition on line `ev_in[src_sel]` captures. An input that changes just before clock edge A is stored at edge A+2. The stored time is the time presented just before that edge.
- R3: With `edge_rise`=0, only a 1-to-0 transition captures. In either mode, a transition in the other direction leaves `cap_valid` and `cap_value` unchanged.
- R4: `src_sel` is the binary index of the watched line, with 0 and 63 as the end values. Transitions on any other line have no effect.
- R5: While `cap_enable`=0, no transition changes `cap_value` or `cap_valid`.
- R6: A capture stores `{time_sec, time_ns}` from one and the same cycle: seconds in bits 63:32, nanoseconds in bits 31:0.
- R7: A capture sets `cap_valid` and overwrites any unread value. A `rd_strobe` in a cycle without a capture clears `cap_valid` at the next edge. A capture in the same cycle as `rd_strobe` leaves `cap_valid` set.
- R8: A selected line held at its active level through reset does not cause a capture after reset is released.
- R9: `cap_value` changes only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 64 | Asynchronous event lines |
| src_sel | input | 6 | Index of the watched line |
| cap_enable | input | 1 | Allows captures when 1 |
| edge_rise | input | 1 | 1: rising edge captures, 0: falling edge captures |
| time_sec | input | 32 | Live seconds from the time counter |
| time_ns | input | 32 | Live nanoseconds from the time counter |
| rd_strobe | input | 1 | Marks the captured value as read |
| cap_value | output | 64 | Captured time, seconds in 63:32, nanoseconds in 31:0 |
| cap_valid | output | 1 | Set by a capture, cleared by a read |

## Verification
The assertions check on every cycle that the flag is set and cleared correctly, that the stored seconds and nanoseconds equal the live pair from the capture cycle, and that the register holds its value at all other times, including while capture is disabled. Some behaviour can only be shown by the bench scenarios. This covers the two-cycle synchronizer latency, which line and which edge direction actually trigger, the suppression of a false edge on a line that is high through reset, and the capture winning over a read in the same cycle.

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture #(
  parameter int N_LINES = 64,
  parameter int SEC_W = 32,
  parameter int NS_W = 32,
  localparam int SEL_W = $clog2(N_LINES),
  localparam int CAP_W = SEC_W + NS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] ev_in,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               cap_enable,
  input  logic               edge_rise,
  input  logic [SEC_W-1:0]   time_sec,
  input  logic [NS_W-1:0]    time_ns,
  input  logic               rd_strobe,
  output logic [CAP_W-1:0]   cap_value,
  output logic               cap_valid
);

  logic       pick;
  logic [2:0] sh;
  logic [1:0] fill;
  logic       armed, rise_seen, fall_seen, take;

  assign pick = ev_in[src_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      fill <= '0;
    end else begin
      sh <= {sh[1:0], pick};
      if (fill != 2'd3) fill <= fill + 2'd1;
    end
  end

  assign armed     = (fill == 2'd3);
  assign rise_seen = sh[1] & ~sh[2];
  assign fall_seen = ~sh[1] & sh[2];
  assign take      = armed & cap_enable & (edge_rise ? rise_seen : fall_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      cap_valid <= 1'b0;
    end else if (take) begin
      cap_value <= {time_sec, time_ns};
      cap_valid <= 1'b1;
    end else if (rd_strobe) begin
      cap_valid <= 1'b0;
    end
  end

endmodule

module evt_stamp_capture_chk #(
  parameter int SEC_W = 32,
  parameter int NS_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  take,
  input logic                  cap_enable,
  input logic                  rd_strobe,
  input logic [SEC_W-1:0]      time_sec,
  input logic [NS_W-1:0]       time_ns,
  input logic [SEC_W+NS_W-1:0] cap_value,
  input logic                  cap_valid
);

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !take |=> !cap_valid);

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && !rd_strobe |=> cap_valid);

  // R6
  capture_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cap_valid && cap_value == {$past(time_sec), $past(time_ns)});

  // R9
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cap_value));

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_enable && !rd_strobe |=> $stable(cap_value) && $stable(cap_valid));

endmodule

bind evt_stamp_capture evt_stamp_capture_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .take(take), .cap_enable(cap_enable),
  .rd_strobe(rd_strobe), .time_sec(time_sec), .time_ns(time_ns),
  .cap_value(cap_value), .cap_valid(cap_valid)
);

// File: tb/evt_stamp_capture_tb_top.sv
`timescale 1ns/1ps
module evt_stamp_capture_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ev_in = '0;
  logic [5:0]  src_sel = '0;
  logic        cap_enable = 1'b0;
  logic        edge_rise = 1'b1;
  logic [31:0] time_sec = '0;
  logic [31:0] time_ns = '0;
  logic        rd_strobe = 1'b0;
  logic [63:0] cap_value;
  logic        cap_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int unsigned cnt = 0;

  always #2 clk = ~clk;

  evt_stamp_capture dut_i (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .src_sel(src_sel),
    .cap_enable(cap_enable), .edge_rise(edge_rise), .time_sec(time_sec),
    .time_ns(time_ns), .rd_strobe(rd_strobe), .cap_value(cap_value),
    .cap_valid(cap_valid)
  );

  // {sel[9:4], rise[3], enable[2], start level[1], capture expected[0]}
  localparam logic [9:0] VEC [8] = '{
    {6'd5,  1'b1, 1'b1, 1'b0, 1'b1},
    {6'd5,  1'b1, 1'b1, 1'b1, 1'b0},
    {6'd40, 1'b0, 1'b1, 1'b1, 1'b1},
    {6'd40, 1'b0, 1'b1, 1'b0, 1'b0},
    {6'd63, 1'b1, 1'b0, 1'b0, 1'b0},
    {6'd0,  1'b1, 1'b1, 1'b0, 1'b1},
    {6'd63, 1'b0, 1'b1, 1'b1, 1'b1},
    {6'd17, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  function automatic logic [63:0] stamp(input int unsigned c);
    logic [31:0] s;
    s = 32'(c * 3 + 7);
    return {s, 32'(c)};
  endfunction

  task automatic step();
    @(negedge clk);
    cnt++;
    {time_sec, time_ns} = stamp(cnt);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
    step();
  endtask

  initial begin
    logic [63:0] held;
    int unsigned ce;
    repeat (3) step();
    chk("R1 valid in reset", 64'(cap_valid), 64'd0);
    chk("R1 value in reset", cap_value, 64'd0);
    rst_n = 1'b1;
    step();
    chk("R1 valid after reset", 64'(cap_valid), 64'd0);

    for (int i = 0; i < 8; i++) begin
      src_sel    = VEC[i][9:4];
      edge_rise  = VEC[i][3];
      cap_enable = 1'b1;
      ev_in      = {64{VEC[i][1]}};
      repeat (6) step();
      clear_flag();
      chk($sformatf("R7 cleared before vector %0d", i), 64'(cap_valid), 64'd0);
      cap_enable = VEC[i][2];
      held = cap_value;
      step();
      ev_in[VEC[i][9:4]] = ~VEC[i][1];
      ce = cnt;
      repeat (3) step();
      if (VEC[i][0]) begin
        chk($sformatf("R2/R3/R4/R6 vector %0d valid", i), 64'(cap_valid), 64'd1);
        chk($sformatf("R2/R3/R4/R6 vector %0d value", i), cap_value, stamp(ce + 2));
      end else begin
        chk($sformatf("R3/R5 vector %0d valid", i), 64'(cap_valid), 64'd0);
        chk($sformatf("R3/R5/R9 vector %0d value", i), cap_value, held);
      end
    end

    // R4: neighbouring lines are ignored
    cap_enable = 1'b1; edge_rise = 1'b1; src_sel = 6'd10; ev_in = '0;
    repeat (6) step();
    clear_flag();
    held = cap_value;
    step();
    ev_in[11] = 1'b1; ev_in[9] = 1'b1;
    repeat (4) step();
    chk("R4 other lines valid", 64'(cap_valid), 64'd0);
    chk("R4 other lines value", cap_value, held);
    ev_in[10] = 1'b1;
    ce = cnt;
    repeat (3) step();
    chk("R4 selected line value", cap_value, stamp(ce + 2));

    // R7: overwrite without a read
    ev_in[10] = 1'b0;
    repeat (4) step();
    ev_in[10] = 1'b1;
    ce = cnt;
    repeat (3) step();
    chk("R7 overwrite valid", 64'(cap_valid), 64'd1);
    chk("R7 overwrite value", cap_value, stamp(ce + 2));

    // R7: a capture wins over a read in the same cycle
    clear_flag();
    ev_in[10] = 1'b0;
    repeat (4) step();
    ev_in[10] = 1'b1;
    ce = cnt;
    step();
    step();
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
    chk("R7 collision valid", 64'(cap_valid), 64'd1);
    chk("R7 collision value", cap_value, stamp(ce + 2));
    held = cap_value;
    clear_flag();
    chk("R7 read clears", 64'(cap_valid), 64'd0);
    chk("R9 read keeps value", cap_value, held);

    // R8: line high through reset
    rst_n = 1'b0; src_sel = 6'd3; edge_rise = 1'b1; cap_enable = 1'b1; ev_in = '1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (8) step();
    chk("R8 no false edge valid", 64'(cap_valid), 64'd0);
    chk("R8 no false edge value", cap_value, 64'd0);
    ev_in[3] = 1'b0;
    repeat (4) step();
    ev_in[3] = 1'b1;
    ce = cnt;
    repeat (3) step();
    chk("R8 armed capture", cap_value, stamp(ce + 2));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule